// File: doc/BRIEF.md
# Instruction Cycle Sequencing Controller

This block is the multi-cycle control unit of a small accumulator machine. It walks each instruction through a fetch subcycle, an optional indirect subcycle, an execute subcycle and, when an interrupt is accepted, an interrupt subcycle. All memory traffic goes through one address register and one data buffer register, in a fixed order of register transfers. An instruction register holds the word being executed, and a program counter and a stack pointer complete the register set.

Memory is reached through a single-port interface with separate read and write strobes and a ready input. A processor status word holds five condition flags from the last addition, together with an interrupt-enable bit and a supervisor-mode bit. The program counter, accumulator, status word and current subcycle are brought out so that the surrounding logic can observe them.

Top module: `instr_cycle_seq`

## Requirements
- R1: In fetch, the program counter is copied into the address register and a read is issued at that address. The returned word goes into the data buffer and then into the instruction register.
- R2: The program counter rises by exactly one during the fetch read, in the first cycle that the read strobe is high. It does so even while ready is still low.
- R3: Instruction words use this layout: bits 15:13 are the opcode, bit 12 is the indirect flag and bits 11:0 are the address. When the indirect flag is set on opcodes 0 to 4, an indirect read at the address field runs before execute, and the low 12 bits of the returned word become the effective address.
- R4: The opcodes are 0 load (accumulator takes the memory word), 1 store (the accumulator is written to memory), 2 add (the memory word is added to the accumulator), 3 jump and 4 jump-if-zero. Jump-if-zero takes the branch only when the zero flag is set. Opcodes 6 and 7 do nothing.
- R5: Add sets the flags from its result. Zero means the result is zero, carry is the carry out of bit 15, sign is bit 15 of the result, overflow means two same-signed operands gave a result of the other sign, and equal means the accumulator equalled the operand before the add.
- R6: No instruction other than add changes the five condition flags.
- R7: An interrupt is entered only at the end of an execute subcycle, when the request input is high and interrupt enable is set. Entry decrements the stack pointer, writes the program counter to the new stack pointer address, and loads the program counter with the handler address (0x080 by default). It also clears interrupt enable and sets supervisor mode.
- R8: While interrupt enable is clear, the request input has no effect.
- R9: Opcode 5 returns from an interrupt. It reads the word at the stack pointer, loads its low 12 bits into the program counter and increments the stack pointer. It also sets interrupt enable and clears supervisor mode.
- R10: Once a strobe is asserted, the address, the strobe and the write data stay unchanged until ready is seen high, so results do not depend on memory latency. Read and write are never asserted together.
- R11: Synchronous active-high reset clears the program counter, the accumulator, the flags and interrupt enable. It sets supervisor mode, loads the stack pointer with its initial value (0x0F0 by default) and starts in fetch.
- R12: The status output carries zero in bit 0, carry in bit 1, sign in bit 2, overflow in bit 3, equal in bit 4, interrupt enable in bit 5 and supervisor in bit 6. The phase output is 0 for fetch, 1 for indirect, 2 for execute and 3 for interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 12 | Memory address, taken from the address register |
| mem_wdata | output | 16 | Write data, taken from the data buffer register |
| mem_rdata | input | 16 | Read data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdy | input | 1 | Access complete |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| psw_o | output | 7 | Status word |
| phase_o | output | 2 | Current subcycle |

## Verification
The hardest situation to reach is a complete interrupt round trip. Interrupt enable is clear after reset, so the stimulus starts with a return-from-interrupt instruction that pops a prepared stack word. That sets interrupt enable and drops to user mode. The request is then held high until the handler's marker store is seen on the bus. Along the way the bench checks the pushed program counter value, the push address and the status word inside the handler, and after the handler's own return it checks that execution resumes at the saved address. The same programs are also run with memory latency set to zero and to three wait cycles.

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
  parameter int DW      = 16,
  parameter int SP_INIT = 'h0F0,
  parameter int IVEC    = 'h080
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  output logic [DW-5:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_rdy,
  output logic [DW-5:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [6:0]    psw_o,
  output logic [1:0]    phase_o
);
  localparam int AW = DW - 4;

  localparam logic [2:0] OP_LD  = 3'd0;
  localparam logic [2:0] OP_ST  = 3'd1;
  localparam logic [2:0] OP_ADD = 3'd2;
  localparam logic [2:0] OP_JMP = 3'd3;
  localparam logic [2:0] OP_JZ  = 3'd4;
  localparam logic [2:0] OP_RTI = 3'd5;

  typedef enum logic [3:0] {
    S_FADDR, S_FREAD, S_FIR,
    S_IADDR, S_IREAD,
    S_EXEC, S_EREAD, S_EALU, S_EWRITE, S_ERTI,
    S_ISAVE, S_IWR
  } state_t;

  state_t          st;
  logic [AW-1:0]   pc, mar, sp;
  logic [DW-1:0]   mbr, ir, acc;
  logic [4:0]      flags;
  logic            ie, sup, bumped;

  wire [2:0]    op   = ir[DW-1:DW-3];
  wire [AW-1:0] ea   = mbr[AW-1:0];
  wire [DW:0]   sum  = {1'b0, acc} + {1'b0, mbr};
  wire          ovf  = (acc[DW-1] == mbr[DW-1]) && (sum[DW-1] != acc[DW-1]);
  wire state_t  tail = (irq && ie) ? S_ISAVE : S_FADDR;

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = (st == S_FREAD) || (st == S_IREAD) || (st == S_EREAD);
  assign mem_wr    = (st == S_EWRITE) || (st == S_IWR);
  assign pc_o      = pc;
  assign acc_o     = acc;
  assign psw_o     = {sup, ie, flags};
  assign phase_o   = (st == S_IADDR || st == S_IREAD) ? 2'd1 :
                     (st == S_ISAVE || st == S_IWR)   ? 2'd3 :
                     (st == S_FADDR || st == S_FREAD || st == S_FIR) ? 2'd0 : 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_FADDR;
      pc     <= '0;
      mar    <= '0;
      mbr    <= '0;
      ir     <= '0;
      acc    <= '0;
      sp     <= AW'(SP_INIT);
      flags  <= '0;
      ie     <= 1'b0;
      sup    <= 1'b1;
      bumped <= 1'b0;
    end else begin
      case (st)
        S_FADDR: begin
          mar    <= pc;
          bumped <= 1'b0;
          st     <= S_FREAD;
        end
        S_FREAD: begin
          if (!bumped) begin
            pc     <= pc + 1'b1;
            bumped <= 1'b1;
          end
          if (mem_rdy) begin
            mbr <= mem_rdata;
            st  <= S_FIR;
          end
        end
        S_FIR: begin
          ir <= mbr;
          st <= (mbr[DW-4] && mbr[DW-1:DW-3] <= OP_JZ) ? S_IADDR : S_EXEC;
        end
        S_IADDR: begin
          mar <= ea;
          st  <= S_IREAD;
        end
        S_IREAD: if (mem_rdy) begin
          mbr <= mem_rdata;
          st  <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_LD, OP_ADD: begin
              mar <= ea;
              st  <= S_EREAD;
            end
            OP_ST: begin
              mar <= ea;
              mbr <= acc;
              st  <= S_EWRITE;
            end
            OP_JMP: begin
              pc <= ea;
              st <= tail;
            end
            OP_JZ: begin
              if (flags[0]) pc <= ea;
              st <= tail;
            end
            OP_RTI: begin
              mar <= sp;
              st  <= S_EREAD;
            end
            default: st <= tail;
          endcase
        end
        S_EREAD: if (mem_rdy) begin
          mbr <= mem_rdata;
          st  <= (op == OP_RTI) ? S_ERTI : S_EALU;
        end
        S_EALU: begin
          if (op == OP_ADD) begin
            acc   <= sum[DW-1:0];
            flags <= {acc == mbr, ovf, sum[DW-1], sum[DW], sum[DW-1:0] == '0};
          end else begin
            acc <= mbr;
          end
          st <= tail;
        end
        S_EWRITE: if (mem_rdy) st <= tail;
        S_ERTI: begin
          pc  <= mbr[AW-1:0];
          sp  <= sp + 1'b1;
          ie  <= 1'b1;
          sup <= 1'b0;
          st  <= tail;
        end
        S_ISAVE: begin
          sp  <= sp - 1'b1;
          mar <= sp - 1'b1;
          mbr <= {{(DW-AW){1'b0}}, pc};
          st  <= S_IWR;
        end
        S_IWR: if (mem_rdy) begin
          pc  <= AW'(IVEC);
          ie  <= 1'b0;
          sup <= 1'b1;
          st  <= S_FADDR;
        end
        default: st <= S_FADDR;
      endcase
    end
  end

  assert_fetch_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (st == S_FADDR) |=> (mem_addr == $past(pc)));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FREAD && !bumped) |=> (pc == $past(pc) + 1'b1));

  assert_flags_only_add_R6: assert property (@(posedge clk) disable iff (rst)
    !(st == S_EALU && op == OP_ADD) |=> $stable(flags));

  assert_int_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_IWR && mem_rdy) |=> (pc == AW'(IVEC) && !ie && sup));

  assert_int_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3 && $past(phase_o) != 2'd3) |-> $past(ie));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_rdy) |=>
      ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr)));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sim_instr_cycle_seq.sv
module sim_instr_cycle_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_rdy;
  logic [11:0] pc_o;
  logic [15:0] acc_o;
  logic [6:0]  psw_o;
  logic [1:0]  phase_o;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  logic [15:0] img [0:255];
  logic [15:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_cycle_seq u0 (
    .clk(clk), .rst(rst), .irq(irq),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy),
    .pc_o(pc_o), .acc_o(acc_o), .psw_o(psw_o), .phase_o(phase_o)
  );

  assign mem_rdy   = (mem_rd || mem_wr) && (wcnt == lat);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
      wcnt <= 0;
    end else if (mem_rd || mem_wr) begin
      wcnt <= mem_rdy ? 0 : wcnt + 1;
      if (mem_wr && mem_rdy) mem[mem_addr[7:0]] <= mem_wdata;
    end else begin
      wcnt <= 0;
    end
  end

  function automatic logic [15:0] ins(input int op, input int ind, input int a);
    return {op[2:0], ind[0], a[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  task automatic start(input int latency);
    lat = latency;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_img();
    img[0] = ins(3, 0, 0);
    lat = 3;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 pc after reset", pc_o, 0);
    chk("R11 acc after reset", acc_o, 0);
    chk("R11/R12 psw after reset", psw_o, 7'h40);
    chk("R12 phase after reset", phase_o, 0);
    rst = 1'b0;
    while (!mem_rd) @(negedge clk);
    chk("R1 fetch address equals pc", mem_addr, pc_o);
    chk("R12 phase during fetch read", phase_o, 0);
    @(negedge clk);
    chk("R2 pc bumped during fetch read", pc_o, 1);
    chk("R2 read still pending", mem_rd, 1);
  endtask

  task automatic t_basic(input int latency, input logic hold_irq);
    clear_img();
    img[0] = ins(0, 0, 'h40);
    img[1] = ins(2, 0, 'h41);
    img[2] = ins(1, 0, 'h42);
    img[3] = ins(3, 0, 3);
    img['h40] = 16'd5;
    img['h41] = 16'd7;
    irq = hold_irq;
    start(latency);
    run(400);
    chk("R4 load/add/store result in memory", mem['h42], 16'd12);
    chk("R4 accumulator after add", acc_o, 16'd12);
    chk("R5 flags for 5+7", psw_o, 7'h40);
    if (hold_irq) begin
      chk("R8 no push while interrupts disabled", mem['hEF], 16'h0000);
      chk("R8 pc never at handler", (pc_o >= 12'h080) ? 1 : 0, 0);
    end
    irq = 1'b0;
  endtask

  task automatic t_indirect(input int latency);
    clear_img();
    img[0] = ins(0, 1, 'h50);
    img[1] = ins(1, 1, 'h51);
    img[2] = ins(3, 1, 'h52);
    img[3] = ins(1, 0, 'h71);
    img[5] = ins(1, 0, 'h70);
    img[6] = ins(3, 0, 6);
    img['h50] = 16'h0060;
    img['h51] = 16'h0061;
    img['h52] = 16'h0005;
    img['h60] = 16'h1234;
    img['h71] = 16'hDEAD;
    start(latency);
    run(400);
    chk("R3 indirect load value", acc_o, 16'h1234);
    chk("R3 indirect store target", mem['h61], 16'h1234);
    chk("R3 indirect jump reached marker", mem['h70], 16'h1234);
    chk("R3 skipped word untouched", mem['h71], 16'hDEAD);
  endtask

  task automatic t_jz_taken();
    clear_img();
    img[0] = ins(0, 0, 'h41);
    img[1] = ins(2, 0, 'h40);
    img[2] = ins(4, 0, 5);
    img[3] = ins(1, 0, 'h70);
    img[4] = ins(3, 0, 4);
    img[5] = ins(1, 0, 'h71);
    img[6] = ins(0, 0, 'h41);
    img[7] = ins(3, 0, 7);
    img['h40] = 16'hFFFF;
    img['h41] = 16'h0001;
    img['h70] = 16'hDEAD;
    img['h71] = 16'hBEEF;
    start(1);
    run(400);
    chk("R4 jz taken skips store", mem['h70], 16'hDEAD);
    chk("R4 jz target store of zero sum", mem['h71], 16'h0000);
    chk("R6 flags kept across load/store/jump", psw_o, 7'h43);
    chk("R6 load after add", acc_o, 16'h0001);
  endtask

  task automatic t_jz_not_taken();
    clear_img();
    img[0] = ins(0, 0, 'h41);
    img[1] = ins(2, 0, 'h41);
    img[2] = ins(4, 0, 5);
    img[3] = ins(1, 0, 'h70);
    img[4] = ins(3, 0, 4);
    img[5] = ins(1, 0, 'h71);
    img['h41] = 16'h0001;
    img['h71] = 16'hBEEF;
    start(2);
    run(400);
    chk("R4 jz not taken falls through", mem['h70], 16'h0002);
    chk("R4 jz not taken target untouched", mem['h71], 16'hBEEF);
    chk("R5 equal flag for 1+1", psw_o, 7'h50);
  endtask

  task automatic t_overflow();
    clear_img();
    img[0] = ins(0, 0, 'h40);
    img[1] = ins(2, 0, 'h41);
    img[2] = ins(6, 0, 0);
    img[3] = ins(3, 0, 3);
    img['h40] = 16'h7FFF;
    img['h41] = 16'h0001;
    start(0);
    run(300);
    chk("R5 overflow sum", acc_o, 16'h8000);
    chk("R5 sign and overflow flags", psw_o, 7'h4C);
  endtask

  task automatic t_interrupt(input int latency);
    logic        seen_push;
    logic [15:0] push_val;
    logic        seen_mark;
    clear_img();
    img[0]     = ins(5, 0, 0);
    img['h10]  = ins(0, 0, 'h40);
    img['h11]  = ins(1, 0, 'h73);
    img['h12]  = ins(3, 0, 'h12);
    img['h40]  = 16'h0ABC;
    img['h80]  = ins(1, 0, 'h72);
    img['h81]  = ins(5, 0, 0);
    img['hF0]  = 16'h0010;
    seen_push = 1'b0;
    seen_mark = 1'b0;
    push_val  = 16'h0000;
    irq = 1'b1;
    start(latency);
    for (int i = 0; i < 600 && !seen_mark; i++) begin
      @(negedge clk);
      if (mem_wr && mem_addr == 12'h0F0 && !seen_push) begin
        seen_push = 1'b1;
        push_val  = mem_wdata;
        chk("R7 interrupt phase during push", phase_o, 3);
      end
      if (mem_wr && mem_addr == 12'h072) seen_mark = 1'b1;
    end
    chk("R7 push seen at decremented stack pointer", seen_push, 1);
    chk("R7 pushed return address", push_val, 16'h0011);
    chk("R7 handler reached", seen_mark, 1);
    chk("R7 status inside handler", psw_o, 7'h40);
    irq = 1'b0;
    run(400);
    chk("R7 handler stored accumulator", mem['h72], 16'h0ABC);
    chk("R9 resumed at saved address", mem['h73], 16'h0ABC);
    chk("R9 status after return", psw_o, 7'h20);
  endtask

  initial begin
    t_reset();
    t_basic(0, 1'b0);
    t_basic(3, 1'b0);
    t_basic(1, 1'b1);
    t_indirect(0);
    t_indirect(3);
    t_jz_taken();
    t_jz_not_taken();
    t_overflow();
    t_interrupt(0);
    t_interrupt(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule